// File: doc/BRIEF.md
# Weighted Modulo 2^n+1 Adder

This block adds two residues held in plain weighted binary and returns their sum modulo 2^n+1. Each operand and the result take n+1 bits and stay in the range 0 to 2^n. The default width n = 8 gives a modulus of 257. The block is meant for the modulo 2^n+1 channel of a residue arithmetic datapath. It is also useful wherever a wrap at 2^n+1 is needed without a division.

The datapath has two stages. A carry-save stage folds the two operands together with a constant. The constant stands for subtracting the modulus. That stage yields an n-bit sum vector and an n-bit carry vector. The top carry wraps around inverted into bit 0.

An n-bit parallel-prefix adder then adds those two vectors. Its carry-in is the inverted carry-out of the same addition, so it acts as an end-around-carry adder. The one result that does not fit in n bits is 2^n. That case is flagged by the group propagate signal that the prefix tree already computes, so no separate zero detector is needed.

The result can be taken combinationally or through an output register with a clock enable. The default is to register the result.

Top module: `mod_weighted_adder`

## Requirements
- R1: For operands A and B in 0..2^n, the result equals A+B when A+B < 2^n+1, and A+B-(2^n+1) otherwise. With n = 8 the modulus is 257.
- R2: When either operand is 0, the result equals the other operand.
- R3: When both operands equal 2^n, the result is 2^n-1. For n = 8 that is 255.
- R4: When A+B equals exactly 2^n, the result is 2^n. The result's bit n is 1 and bits n-1..0 are all 0.
- R5: When A+B equals exactly 2^n+1, the result is 0.
- R6: With output registering on (REG_OUT = 1, the default), `sum` shows the result of the operands present at the first rising `clk` edge where `en` is 1. `sum` is visible from that edge onward. While `en` is 0, `sum` keeps its value whatever the operands do.
- R7: A low level on `rst_n` clears `sum` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| en | input | 1 | Clock enable of the output register |
| a | input | N+1 | First operand, weighted, 0..2^N |
| b | input | N+1 | Second operand, weighted, 0..2^N |
| sum | output | N+1 | Weighted residue (a+b) mod 2^N+1 |

## Verification
A wrong bit in the constant that encodes the subtraction, or in the wrapped carry vector, shifts the result by a fixed amount for a whole class of operand pairs. That error appears at `sum` one clock after those operands are sampled. A broken node in the prefix tree or a missing end-around inversion shows up only for the operand pairs whose carries pass through that node. For that reason the bench sweeps every legal pair for n = 8 and names the R2 to R5 corners separately. The 2^n case (R4) is the only path where the propagate flag alone sets bit n, so a fault there is visible only on pairs that sum to 2^n.

// File: rtl/mwa_pkg.sv
package mwa_pkg;

  // Number of prefix levels needed so that a span of 2**levels covers width bits.
  function automatic int prefix_levels(input int width);
    int lv;
    lv = 0;
    while ((1 << lv) < width) lv++;
    return lv;
  endfunction

endpackage

// File: rtl/mwa_offset_csa.sv
module mwa_offset_csa #(
  parameter int N = 8
) (
  input  logic [N-1:0] a_lo,
  input  logic [N-1:0] b_lo,
  input  logic         a_top,
  input  logic         b_top,
  output logic [N-1:0] s_vec,
  output logic [N-1:0] c_vec
);

  localparam int TOP = 1 << N;
  localparam int MOD = TOP + 1;

  // Constant equal to 2^N - 1 - (a_top + b_top). It folds in the top operand
  // bits (weight 2^N counts as -1) together with the removal of the modulus.
  logic [N-1:0] k_vec;
  logic [N-1:0] maj;

  always_comb begin
    k_vec    = '1;
    k_vec[1] = ~(a_top & b_top);
    k_vec[0] = ~(a_top ^ b_top);
  end

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_fa
      assign s_vec[i] = a_lo[i] ^ b_lo[i] ^ k_vec[i];
      assign maj[i]   = (a_lo[i] & b_lo[i]) | (a_lo[i] & k_vec[i]) | (b_lo[i] & k_vec[i]);
    end
  endgenerate

  // The carry leaving bit N-1 has weight 2^N (counts as -1). It re-enters at bit 0 inverted.
  assign c_vec = {maj[N-2:0], ~maj[N-1]};

  // The two vectors must be congruent to A+B-1 modulo 2^N+1.
  generate
    if (N <= 20) begin : g_chk
      int unsigned lhs_val;
      int unsigned rhs_val;
      always_comb begin
        lhs_val = (int'(s_vec) + int'(c_vec)) % MOD;
        rhs_val = (int'(a_lo) + int'(b_lo) + (int'(a_top) + int'(b_top)) * TOP + MOD - 1) % MOD;
        a_r1_offset_congruent: assert (lhs_val == rhs_val);
      end
    end
  endgenerate

endmodule

// File: rtl/mwa_eac_core.sv
module mwa_eac_core #(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N:0]   res
);

  localparam int LV = mwa_pkg::prefix_levels(N);

  logic [N-1:0] hsum;
  logic [N-1:0] gt [0:LV];
  logic [N-1:0] pt [0:LV];
  logic [N-1:0] carry;
  logic [N-1:0] low;
  logic         cout;
  logic         eac;
  logic         all_prop;

  assign hsum  = x ^ y;
  assign gt[0] = x & y;
  assign pt[0] = hsum;

  // Prefix tree with log2 depth: after level l each node spans 2^(l+1) bits down to bit 0.
  genvar l, i;
  generate
    for (l = 0; l < LV; l++) begin : g_lvl
      for (i = 0; i < N; i++) begin : g_node
        if (i >= (1 << l)) begin : g_comb
          assign gt[l+1][i] = gt[l][i] | (pt[l][i] & gt[l][i-(1<<l)]);
          assign pt[l+1][i] = pt[l][i] & pt[l][i-(1<<l)];
        end else begin : g_pass
          assign gt[l+1][i] = gt[l][i];
          assign pt[l+1][i] = pt[l][i];
        end
      end
    end
  endgenerate

  // Inverted end-around carry: the carry-out of x+y, inverted, is the carry-in.
  assign cout     = gt[LV][N-1];
  assign eac      = ~cout;
  assign all_prop = pt[LV][N-1];
  assign carry    = gt[LV] | (pt[LV] & {N{eac}});
  assign low      = hsum ^ {carry[N-2:0], eac};

  // A full propagate run means x+y = 2^N-1. The residue is then 2^N.
  assign res = all_prop ? {1'b1, {N{1'b0}}} : {1'b0, low};

endmodule

// File: rtl/mod_weighted_adder.sv
module mod_weighted_adder #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N:0]   a,
  input  logic [N:0]   b,
  output logic [N:0]   sum
);

  localparam int TOP = 1 << N;
  localparam int MOD = TOP + 1;

  logic [N-1:0] s_vec;
  logic [N-1:0] c_vec;
  logic [N:0]   res;

  mwa_offset_csa #(.N(N)) u_csa (
    .a_lo  (a[N-1:0]),
    .b_lo  (b[N-1:0]),
    .a_top (a[N]),
    .b_top (b[N]),
    .s_vec (s_vec),
    .c_vec (c_vec)
  );

  mwa_eac_core #(.N(N)) u_core (
    .x   (s_vec),
    .y   (c_vec),
    .res (res)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [N:0] sum_d;
      logic [N:0] sum_q;

      always_comb begin
        sum_d = sum_q;
        if (en) sum_d = res;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
      end

      assign sum = sum_q;

      a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sum_q) <= TOP);

      a_r1_modsum: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (int'(sum_q) == (int'($past(a)) + int'($past(b))) % MOD));

      a_r2_zero_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (en && b == '0) |=> (sum_q == $past(a)));

      a_r3_both_max: assert property (@(posedge clk) disable iff (!rst_n)
        (en && int'(a) == TOP && int'(b) == TOP) |=> (int'(sum_q) == TOP - 1));

      a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(sum_q));
    end else begin : g_comb
      assign sum = res;
    end
  endgenerate

endmodule

// File: tb/mod_weighted_adder_tb.sv
module mod_weighted_adder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int TOP = 1 << N;
  localparam int MOD = TOP + 1;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic [N:0] a;
  logic [N:0] b;
  logic [N:0] sum;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  mod_weighted_adder #(.N(N), .REG_OUT(1'b1)) u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .a     (a),
    .b     (b),
    .sum   (sum)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_pair(input int pa, input int pb);
    int    exp;
    string tag;
    exp = (pa + pb < MOD) ? pa + pb : pa + pb - MOD;
    if (pa == TOP && pb == TOP)  tag = "R3 both max";
    else if (pa == 0 || pb == 0) tag = "R2 zero operand";
    else if (pa + pb == MOD)     tag = "R5 sum equals modulus";
    else if (pa + pb == TOP)     tag = "R4 sum equals 2^n";
    else                         tag = "R1 modular sum";
    check($sformatf("%s a=%0d b=%0d", tag, pa, pb), int'(sum), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int pa;
    int pb;
    bit have;
    rst_n = 1'b0;
    en    = 1'b0;
    a     = '0;
    b     = '0;
    have  = 1'b0;
    pa    = 0;
    pb    = 0;
    repeat (2) @(negedge clk);
    check("R7 reset state", int'(sum), 0);
    rst_n = 1'b1;

    // R1..R5, R6: full sweep, one pair per cycle, result checked one cycle later
    for (int ia = 0; ia <= TOP; ia++) begin
      for (int ib = 0; ib <= TOP; ib++) begin
        @(negedge clk);
        if (have) check_pair(pa, pb);
        a    = ia[N:0];
        b    = ib[N:0];
        en   = 1'b1;
        pa   = ia;
        pb   = ib;
        have = 1'b1;
      end
    end
    @(negedge clk);
    check_pair(pa, pb);

    // R6: enable low keeps the last result while operands change
    en = 1'b0;
    a  = 9'd5;
    b  = 9'd7;
    @(negedge clk);
    check("R6 hold with en low", int'(sum), 255);
    a = 9'd100;
    @(negedge clk);
    check("R6 hold second cycle", int'(sum), 255);

    // R7: asynchronous clear between clock edges
    en = 1'b1;
    a  = 9'd3;
    b  = 9'd4;
    @(negedge clk);
    check("R1 before reset", int'(sum), 7);
    en = 1'b0;
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R7 asynchronous clear", int'(sum), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 stays clear after release", int'(sum), 0);

    // R6 latency after reset: first enabled edge loads the result
    en = 1'b1;
    a  = 9'd256;
    b  = 9'd1;
    @(negedge clk);
    check("R5 after reset", int'(sum), 0);
    a = 9'd200;
    b = 9'd100;
    @(negedge clk);
    check("R6 single cycle latency", int'(sum), 43);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule